// File: doc/BRIEF.md
# Dual Down-Counter Timer

This peripheral holds two independent 32-bit down-counters behind a flat 32-bit register port. Each timer has a reload register, a control register and a readable count. Its tick rate is picked from four single-cycle enable strobes that arrive from elsewhere on the chip. A timer that runs out reloads itself and raises a pending bit. The two pending bits pass through a mask and are OR-ed into one level-sensitive interrupt line. Software clears a pending bit by writing a one to its position in an acknowledge register.

Software stores a reload value first, because a reload write has no effect on the counter. A later control write then loads the counter, stops it or starts it. The host reads the raw pending bits at one offset and their masked view at another. Any offset that is not mapped reads as zero, and a write to it is dropped.

Top module: `dual_timer`

## Requirements
- R1: After reset both timers are stopped, every reload, count and control register reads 0, the raw status and the mask read 0, and `irq` is low.
- R2: A write to the reload register (byte offset 0x00 for timer 0, 0x10 for timer 1) stores the value, which reads back at that offset. The write leaves the counter unchanged.
- R3: A control write (0x08 / 0x18) acts on bits [1:0]. Code 0 copies the reload value into the counter and keeps the run state. Code 1 stops the timer. Code 2 makes it run. A write with code 3 is dropped as a whole, so the control register keeps its old value. Control reads return bits [4:0] of the last accepted write.
- R4: Control bits [4:2] choose the tick source. Codes 4, 5, 6 and 7 select `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]`. Codes 0 to 3 give no ticks. A running timer whose count is not zero decrements by one on each cycle in which its selected strobe is high. The count reads at 0x04 / 0x14.
- R5: When a running timer is ticked at count 0, it reloads from its reload register and sets raw status bit 0 (timer 0) or bit 1 (timer 1). Raw status reads at 0x50. A control write in the same cycle takes priority over the tick.
- R6: Writing the acknowledge register (0x4C) clears each raw status bit that is one in the written value. The register reads as 0. If an expiry and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R7: The mask register (0x48, bits [1:0]) reads back. Offset 0x54 reads raw status AND mask. `irq` is high exactly when that AND is non-zero, and it follows a mask write from the next clock.
- R8: Reads of any other offset return 0. Writes to the count, raw status, masked status and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 4 | Four tick-source enable strobes |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
The assertions check on every cycle the following rules:
- a stopped counter holds its value;
- a selected tick decrements a non-zero count by exactly one;
- an expiry leaves its pending bit set;
- an acknowledge without a coincident expiry clears the bit;
- a code-3 control write leaves the control register unchanged;
- `irq` never rises while the mask is empty.

The bench's scenarios show what those rules cannot:
- the reload value actually arrives on load and on wrap;
- the source codes map to the right strobes;
- the expiry-wins race resolves as specified;
- the readback values at each offset, including zeros from the acknowledge and unmapped offsets.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    tick_en,
  output logic          irq
);
  localparam logic [AW-1:0] A_REL0 = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT0 = AW'(8'h04);
  localparam logic [AW-1:0] A_CTL0 = AW'(8'h08);
  localparam logic [AW-1:0] A_REL1 = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT1 = AW'(8'h14);
  localparam logic [AW-1:0] A_CTL1 = AW'(8'h18);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h48);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h4C);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h50);
  localparam logic [AW-1:0] A_MSKD = AW'(8'h54);

  logic [DW-1:0] rel_q [2];
  logic [DW-1:0] cnt_q [2];
  logic [4:0]    ctl_q [2];
  logic [1:0]    run_q, raw_q, mask_q;
  logic [1:0]    relw_v, ctlw_v, tick_v, expire_v;
  logic [1:0]    ack_clr;
  logic          ack_wr;

  assign ack_wr  = bus_we && bus_addr == A_ACK;
  assign ack_clr = ack_wr ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      relw_v[i]   = bus_we && bus_addr == (i == 0 ? A_REL0 : A_REL1);
      ctlw_v[i]   = bus_we && bus_addr == (i == 0 ? A_CTL0 : A_CTL1) && bus_wdata[1:0] != 2'd3;
      tick_v[i]   = run_q[i] && ctl_q[i][4] && tick_en[ctl_q[i][3:2]];
      expire_v[i] = tick_v[i] && !ctlw_v[i] && cnt_q[i] == '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        rel_q[i] <= '0;
        cnt_q[i] <= '0;
        ctl_q[i] <= '0;
      end
      run_q  <= '0;
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (relw_v[i]) rel_q[i] <= bus_wdata;
        if (ctlw_v[i]) begin
          ctl_q[i] <= bus_wdata[4:0];
          case (bus_wdata[1:0])
            2'd0:    cnt_q[i] <= rel_q[i];
            2'd1:    run_q[i] <= 1'b0;
            default: run_q[i] <= 1'b1;
          endcase
        end else if (tick_v[i]) begin
          cnt_q[i] <= (cnt_q[i] == '0) ? rel_q[i] : cnt_q[i] - 1'b1;
        end
      end
      if (bus_we && bus_addr == A_MSK) mask_q <= bus_wdata[1:0];
      raw_q <= (raw_q & ~ack_clr) | expire_v;
    end
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    case (bus_addr)
      A_REL0:  bus_rdata = rel_q[0];
      A_CNT0:  bus_rdata = cnt_q[0];
      A_CTL0:  bus_rdata = DW'(ctl_q[0]);
      A_REL1:  bus_rdata = rel_q[1];
      A_CNT1:  bus_rdata = cnt_q[1];
      A_CTL1:  bus_rdata = DW'(ctl_q[1]);
      A_MSK:   bus_rdata = DW'(mask_q);
      A_RAW:   bus_rdata = DW'(raw_q);
      A_MSKD:  bus_rdata = DW'(raw_q & mask_q);
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[g] && !ctlw_v[g]) |=> $stable(cnt_q[g]));
    p_op3_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == (g == 0 ? A_CTL0 : A_CTL1) && bus_wdata[1:0] == 2'd3) |=> $stable(ctl_q[g]));
    p_tick_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_v[g] && !ctlw_v[g] && cnt_q[g] != '0) |=> cnt_q[g] == $past(cnt_q[g]) - 1'b1);
    p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[g] |=> raw_q[g]);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && bus_wdata[g] && !expire_v[g]) |=> !raw_q[g]);
  end

  p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 2'b00));
endmodule

// File: tb/tb_dual_timer.sv
`timescale 1ns/100ps
module tb_dual_timer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = 0;
  logic        irq;

  dual_timer dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_rel [2], m_cnt [2];
  logic [4:0]  m_ctl [2];
  logic [1:0]  m_run, m_raw, m_mask;
  logic [31:0] last_rd;
  logic        last_irq;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_rel[0];
      8'h04: return m_cnt[0];
      8'h08: return {27'd0, m_ctl[0]};
      8'h10: return m_rel[1];
      8'h14: return m_cnt[1];
      8'h18: return {27'd0, m_ctl[1]};
      8'h48: return {30'd0, m_mask};
      8'h50: return {30'd0, m_raw};
      8'h54: return {30'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00, 8'h10: return "R2 reload read";
      8'h04, 8'h14: return "R4 count read";
      8'h08, 8'h18: return "R3 control read";
      8'h48, 8'h54: return "R7 mask read";
      8'h50:        return "R5 status read";
      default:      return "R8 unmapped read";
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin m_rel[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; end
    m_run = 0; m_raw = 0; m_mask = 0;
  endtask

  task automatic m_update(logic we, logic [7:0] a, logic [31:0] wd, logic [3:0] tk);
    logic [1:0] ex = 0;
    for (int i = 0; i < 2; i++) begin
      logic ctlw = we && a == 8'(16*i + 8) && wd[1:0] != 2'd3;
      logic tick = m_run[i] && m_ctl[i][4] && tk[m_ctl[i][3:2]];
      if (ctlw) begin
        m_ctl[i] = wd[4:0];
        if (wd[1:0] == 0) m_cnt[i] = m_rel[i];
        else if (wd[1:0] == 1) m_run[i] = 0;
        else m_run[i] = 1;
      end else if (tick) begin
        if (m_cnt[i] == 0) begin m_cnt[i] = m_rel[i]; ex[i] = 1; end
        else m_cnt[i] = m_cnt[i] - 1;
      end
      if (we && a == 8'(16*i)) m_rel[i] = wd;
    end
    if (we && a == 8'h48) m_mask = wd[1:0];
    m_raw = (m_raw & ~((we && a == 8'h4C) ? wd[1:0] : 2'b00)) | ex;
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] wd, logic [3:0] tk);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; tick_en = tk;
    #1;
    last_rd = bus_rdata; last_irq = irq;
    chk(tag_of(a), bus_rdata, m_read(a));
    chk("R7 irq level", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    @(posedge clk);
    m_update(we, a, wd, tk);
  endtask

  task automatic expect_rd(logic [7:0] a, logic [31:0] exp, string tag);
    step(0, a, 0, 0);
    chk(tag, last_rd, exp);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] amap [12] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18,
                              8'h48, 8'h4C, 8'h50, 8'h54, 8'h20, 8'h0C};
    void'($urandom(32'h5eed));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    for (int k = 0; k < 12; k++) expect_rd(amap[k], 0, "R1 reset value");
    chk("R1 irq low", {31'd0, irq}, 0);
    // R2 reload stored, counter untouched
    step(1, 8'h00, 32'd3, 0);
    expect_rd(8'h00, 3, "R2 reload readback");
    expect_rd(8'h04, 0, "R2 count unchanged");
    // R3 load (src 4 -> tick_en[0]), code 3 dropped, run
    step(1, 8'h08, 32'h10, 0);
    expect_rd(8'h04, 3, "R3 load op");
    step(1, 8'h08, 32'h1F, 0);
    expect_rd(8'h08, 32'h10, "R3 code 3 ignored");
    step(1, 8'h08, 32'h12, 0);
    // R4 wrong strobe ignored, right one decrements
    step(0, 8'h04, 0, 4'b1110);
    expect_rd(8'h04, 3, "R4 unselected strobe");
    step(0, 8'h04, 0, 4'b0001);
    expect_rd(8'h04, 2, "R4 decrement");
    step(0, 8'h04, 0, 4'b0001);
    step(0, 8'h04, 0, 4'b0001);
    expect_rd(8'h04, 0, "R4 reached zero");
    expect_rd(8'h50, 0, "R5 no early expiry");
    // R5 wrap
    step(0, 8'h04, 0, 4'b0001);
    expect_rd(8'h04, 3, "R5 reload on wrap");
    expect_rd(8'h50, 1, "R5 status bit0");
    chk("R7 irq masked off", {31'd0, last_irq}, 0);
    // R7 mask
    step(1, 8'h48, 32'h1, 0);
    expect_rd(8'h54, 1, "R7 masked view");
    chk("R7 irq after mask", {31'd0, last_irq}, 1);
    // R6 ack
    step(1, 8'h4C, 32'h1, 0);
    expect_rd(8'h50, 0, "R6 ack clears");
    expect_rd(8'h4C, 0, "R6 ack reads zero");
    chk("R6 irq dropped", {31'd0, last_irq}, 0);
    repeat (3) step(0, 8'h04, 0, 4'b0001);
    step(1, 8'h4C, 32'h1, 4'b0001);
    expect_rd(8'h50, 1, "R6 expiry wins over ack");
    // R8 ignored writes
    step(1, 8'h04, 32'hDEAD, 0);
    expect_rd(8'h04, 3, "R8 count write ignored");
    step(1, 8'h50, 32'h0, 0);
    expect_rd(8'h50, 1, "R8 status write ignored");
    step(1, 8'h20, 32'hFFFF, 0);
    expect_rd(8'h20, 0, "R8 unmapped");
    // random mix on both timers
    for (int n = 0; n < 5000; n++) begin
      logic [7:0]  a  = amap[$urandom % 12];
      logic        we = ($urandom % 4) == 0;
      logic [31:0] wd;
      case (a)
        8'h00, 8'h10: wd = $urandom % 6;
        8'h08, 8'h18: wd = (($urandom % 8) << 2) | ($urandom % 4);
        8'h48, 8'h4C: wd = $urandom % 4;
        default:      wd = $urandom;
      endcase
      step(we, a, wd, 4'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule